// File: doc/BRIEF.md
# Key-Gated Banked Register Access Unit

This block is the byte-wide register front end of a UART-style peripheral that has eight address offsets. In its normal view every offset reaches one plain storage byte, and offset 3 serves as the line-control register. When the key value 0xBF is written to line control, an enhanced view opens. In that view, offset 2 reaches a feature register. Offsets 4 to 7 reach one of several register banks, and the bank is picked by the two top bits of the feature register. Writing any other value to line control closes the view again. Closing the view does not disturb the contents of any bank.

A small two-state machine tracks whether the view is open. Its states are VIEW_CLOSED and VIEW_OPEN, and its transitions are:

- KEY_WRITE: a line-control write of 0xBF moves either state to VIEW_OPEN.
- OTHER_WRITE: a line-control write of any other value moves either state to VIEW_CLOSED.
- HOLD: every other cycle keeps the state.

A decoder uses the state, the offset and the bank field to choose one target: plain storage, the feature register, a banked register, or nothing. Reads are registered. The bank contents, the feature register and the plain storage are exported in parallel so that the rest of the UART can use them.

Top module: `banked_reg_unit`

## Requirements
- R1: After reset the view is closed and rd_data reads 0x00. Every plain storage byte, the feature register and every writable banked register are 0x00. The hardware-ID byte holds HW_ID (0x01 by default).
- R2: A write to offset 3 stores the byte, and that byte reads back at offset 3 in either view. The value 0xBF opens the view (view_open=1 from the next cycle). Any other value closes it.
- R3: While the view is open, offset 2 reads and writes the feature register and returns the value last written to it. While the view is closed, offset 2 reaches a separate plain byte, and writes there leave the feature register unchanged.
- R4: Feature bits [7:6] select the bank (0x00, 0x40, 0x80, 0xC0 give banks 0 to 3). In bank 0, offsets 4 to 7 hold XON1, XON2, XOFF1 and XOFF2, exported as bank_regs bytes 0 to 3.
- R5: In bank 1, offsets 4 to 7 hold the receive low threshold, receive high threshold, receive trigger level and transmit low threshold, exported as bank_regs bytes 4 to 7.
- R6: In bank 2, offsets 4, 6 and 7 hold the enumeration, extended control and control/status bytes (bank_regs bytes 8, 10 and 11). Offset 5 always reads HW_ID (bank_regs byte 9), and writes to it are ignored.
- R7: In bank 3, offsets 4 to 7 read as 0x00, and writes to them change no register.
- R8: While the view is closed, offsets 4 to 7 reach plain storage (std_regs bytes 4 to 7). Banked contents are kept across closing and reopening the view.
- R9: A read presents data on rd_data one cycle after rd_en. When a read and a write hit the same register in the same cycle, the read returns the value from before the write. rd_data holds while rd_en is low.
- R10: enh_en equals feature bit 4, and bank_sel equals feature bits [7:6].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| view_open | output | 1 | Enhanced view is open |
| enh_en | output | 1 | Enhanced mode enable (feature bit 4) |
| bank_sel | output | 2 | Selected bank (feature bits 7:6) |
| efr_q | output | 8 | Feature register contents |
| std_regs | output | 64 | Plain storage, byte i is offset i (byte 3 is line control) |
| bank_regs | output | 96 | Banks 0 to 2, four bytes each, slot order offset 4 to 7 |

## Verification
A wrong view state shows up at once as a view_open level that does not match the last line-control byte. It also sends the next offset-2 or offset-4-to-7 access to the wrong register, which is visible on the exported vectors one cycle after that write. A corrupted bank field moves banked writes into a neighbouring bank's bytes, or makes a bank-3 write alter stored data, so the exported bank bytes differ after the next write. A stale or misrouted read path shows up on rd_data one cycle after the read strobe.

// File: rtl/bank_reg_pkg.sv
package bank_reg_pkg;

    // Offsets whose meaning the decoder depends on
    localparam int LCR_OFS  = 3;
    localparam int FEAT_OFS = 2;
    localparam int ENH_BIT  = 4;

    typedef enum logic {
        VIEW_CLOSED = 1'b0,
        VIEW_OPEN   = 1'b1
    } view_state_t;

    typedef enum logic [1:0] {
        TGT_STD  = 2'd0,
        TGT_FEAT = 2'd1,
        TGT_BANK = 2'd2,
        TGT_NONE = 2'd3
    } target_t;

endpackage

// File: rtl/bank_view_fsm.sv
module bank_view_fsm
    import bank_reg_pkg::*;
#(
    parameter int          DW  = 8,
    parameter logic [DW-1:0] KEY = 8'hBF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lcr_wr,
    input  logic [DW-1:0] wr_data,
    output logic          view_open
);

    view_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VIEW_CLOSED;
        else        state_q <= state_d;
    end

    // Transitions: KEY_WRITE, OTHER_WRITE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VIEW_CLOSED: if (lcr_wr && wr_data == KEY) state_d = VIEW_OPEN;
            VIEW_OPEN:   if (lcr_wr && wr_data != KEY) state_d = VIEW_CLOSED;
            default:     state_d = VIEW_CLOSED;
        endcase
    end

    // Outputs
    always_comb begin
        view_open = 1'b0;
        unique case (state_q)
            VIEW_CLOSED: view_open = 1'b0;
            VIEW_OPEN:   view_open = 1'b1;
            default:     view_open = 1'b0;
        endcase
    end

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr && wr_data == KEY) |=> view_open);
    // R2
    other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr && wr_data != KEY) |=> !view_open);
    // R2
    view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr |=> $stable(view_open));

endmodule

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
    import bank_reg_pkg::*;
#(
    parameter int AW = 3,
    parameter int BW = 2,
    parameter int SW = 2
) (
    input  logic [AW-1:0] addr,
    input  logic          view_open,
    input  logic [BW-1:0] bank_sel,
    output target_t       tgt,
    output logic [BW-1:0] bank,
    output logic [SW-1:0] slot
);

    localparam logic [BW-1:0] DEAD_BANK = {BW{1'b1}};

    always_comb begin
        bank = bank_sel;
        slot = addr[SW-1:0];
        tgt  = TGT_STD;
        unique case (view_open)
            1'b0: tgt = TGT_STD;
            1'b1: begin
                if (addr == AW'(FEAT_OFS))
                    tgt = TGT_FEAT;
                else if (addr[AW-1])
                    tgt = (bank_sel == DEAD_BANK) ? TGT_NONE : TGT_BANK;
                else
                    tgt = TGT_STD;
            end
            default: tgt = TGT_STD;
        endcase
    end

endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file #(
    parameter int          DW     = 8,
    parameter int          NSLOT  = 4,
    parameter int          RO_SLOT = -1,
    parameter logic [DW-1:0] RO_VAL = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    slot_we,
    input  logic [DW-1:0]       wr_data,
    output logic [NSLOT*DW-1:0] regs_flat
);

    logic [DW-1:0] q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam bit IS_RO = (s == RO_SLOT);
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[s] <= IS_RO ? RO_VAL : '0;
            else if (slot_we[s] && !IS_RO)
                q[s] <= wr_data;
        end
        assign regs_flat[s*DW +: DW] = q[s];
    end

    if (RO_SLOT >= 0 && RO_SLOT < NSLOT) begin : g_ro_chk
        // R6
        ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_we[RO_SLOT] |=> (regs_flat[RO_SLOT*DW +: DW] == RO_VAL));
    end

endmodule

// File: rtl/banked_reg_unit.sv
module banked_reg_unit
    import bank_reg_pkg::*;
#(
    parameter int            DW    = 8,
    parameter int            AW    = 3,
    parameter logic [DW-1:0] KEY   = 8'hBF,
    parameter logic [DW-1:0] HW_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    output logic              view_open,
    output logic              enh_en,
    output logic [1:0]        bank_sel,
    output logic [DW-1:0]     efr_q,
    output logic [8*DW-1:0]   std_regs,
    output logic [12*DW-1:0]  bank_regs
);

    localparam int NOFS   = 1 << AW;
    localparam int BW     = 2;
    localparam int NBANK  = 1 << BW;
    localparam int SW     = AW - 1;
    localparam int NSLOT  = 1 << SW;
    localparam int NSTORE = NBANK - 1;
    localparam int ID_BANK = 2;
    localparam int ID_SLOT = 1;

    target_t         tgt;
    logic [BW-1:0]   bank;
    logic [SW-1:0]   slot;
    logic [NSLOT-1:0] slot_oh;
    logic [DW-1:0]   std_q   [NOFS];
    logic [DW-1:0]   bank_rd [NBANK];
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   rd_q;
    logic [DW-1:0]   feat_q;

    bank_view_fsm #(.DW(DW), .KEY(KEY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lcr_wr    (wr_en && addr == AW'(LCR_OFS)),
        .wr_data   (wr_data),
        .view_open (view_open)
    );

    bank_addr_decode #(.AW(AW), .BW(BW), .SW(SW)) u_dec (
        .addr      (addr),
        .view_open (view_open),
        .bank_sel  (bank_sel),
        .tgt       (tgt),
        .bank      (bank),
        .slot      (slot)
    );

    assign slot_oh = NSLOT'(1) << slot;

    // Plain storage, offset 3 doubles as line control
    for (genvar i = 0; i < NOFS; i++) begin : g_std
        always_ff @(posedge clk) begin
            if (!rst_n)
                std_q[i] <= '0;
            else if (wr_en && tgt == TGT_STD && addr == AW'(i))
                std_q[i] <= wr_data;
        end
        assign std_regs[i*DW +: DW] = std_q[i];
    end

    // Feature register
    always_ff @(posedge clk) begin
        if (!rst_n)
            feat_q <= '0;
        else if (wr_en && tgt == TGT_FEAT)
            feat_q <= wr_data;
    end
    assign efr_q    = feat_q;
    assign bank_sel = feat_q[DW-1 -: BW];
    assign enh_en   = feat_q[ENH_BIT];

    // Storage banks
    for (genvar b = 0; b < NSTORE; b++) begin : g_bank
        logic [NSLOT*DW-1:0] flat;
        bank_reg_file #(
            .DW      (DW),
            .NSLOT   (NSLOT),
            .RO_SLOT ((b == ID_BANK) ? ID_SLOT : -1),
            .RO_VAL  ((b == ID_BANK) ? HW_ID : '0)
        ) u_file (
            .clk       (clk),
            .rst_n     (rst_n),
            .slot_we   ((wr_en && tgt == TGT_BANK && bank == BW'(b)) ? slot_oh : '0),
            .wr_data   (wr_data),
            .regs_flat (flat)
        );
        assign bank_regs[b*NSLOT*DW +: NSLOT*DW] = flat;
        assign bank_rd[b] = flat[slot*DW +: DW];
    end
    assign bank_rd[NBANK-1] = '0;

    // Read selection
    always_comb begin
        rd_mux = '0;
        unique case (tgt)
            TGT_STD:  rd_mux = std_q[addr];
            TGT_FEAT: rd_mux = feat_q;
            TGT_BANK: rd_mux = bank_rd[bank];
            TGT_NONE: rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end
    assign rd_data = rd_q;

    // R2
    view_matches_lcr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        view_open == (std_q[LCR_OFS] == KEY));
    // R3
    feat_locked_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !view_open |=> $stable(feat_q));
    // R7
    dead_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == TGT_NONE) |=> $stable(bank_regs));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R8
    bank_kept_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !view_open |=> $stable(bank_regs));

endmodule

// File: tb/banked_reg_unit_test.sv
module banked_reg_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        view_open;
    logic        enh_en;
    logic [1:0]  bank_sel;
    logic [7:0]  efr_q;
    logic [63:0] std_regs;
    logic [95:0] bank_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       took;

    banked_reg_unit uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .view_open(view_open), .enh_en(enh_en), .bank_sel(bank_sel),
        .efr_q(efr_q), .std_regs(std_regs), .bank_regs(bank_regs)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data after each captured read
    always @(posedge clk) begin
        took = rd_en && rst_n;
        #5;
        if (took) begin
            if (exp_q.size() == 0) check("R9 unexpected read", 1, 0);
            else check(tag_q.pop_front(), {88'h0, rd_data}, {88'h0, exp_q.pop_front()});
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_rw(input logic [2:0] a, input logic [7:0] d, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        check("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 view_open", {95'h0, view_open}, 0);
        check("R1 rd_data", {88'h0, rd_data}, 0);
        check("R1 std_regs", {32'h0, std_regs}, 0);
        check("R1 bank_regs", bank_regs, {32'h0000_0100, 64'h0});
        check("R1 efr", {88'h0, efr_q}, 0);

        // R8 closed view plain storage
        do_write(3'd4, 8'h11); do_write(3'd5, 8'h22);
        do_write(3'd6, 8'h33); do_write(3'd7, 8'h44);
        do_write(3'd2, 8'h55);
        do_read(3'd4, 8'h11, "R8 closed off4");
        do_read(3'd7, 8'h44, "R8 closed off7");
        check("R8 std bytes", {32'h0, std_regs}, {64'h4433_2211_0055_0000});
        check("R8 banks untouched", bank_regs, {32'h0000_0100, 64'h0});
        check("R3 efr untouched closed", {88'h0, efr_q}, 0);

        // R2 open
        do_write(3'd3, 8'hBF);
        check("R2 view opens", {95'h0, view_open}, 1);
        do_read(3'd3, 8'hBF, "R2 lcr readback");
        do_read(3'd2, 8'h00, "R3 efr reset read");
        do_write(3'd2, 8'h10);
        check("R10 enh_en", {95'h0, enh_en}, 1);
        check("R10 bank_sel0", {94'h0, bank_sel}, 0);

        // R4 bank 0
        do_write(3'd4, 8'hA1); do_write(3'd5, 8'hA2);
        do_write(3'd6, 8'hA3); do_write(3'd7, 8'hA4);
        check("R4 bank0 export", {64'h0, bank_regs[31:0]}, {64'h0, 32'hA4A3_A2A1});
        do_read(3'd5, 8'hA2, "R4 xon2 read");
        check("R8 std kept open", {64'h0, std_regs[63:32]}, {64'h0, 32'h4433_2211});

        // R5 bank 1
        do_write(3'd2, 8'h50);
        check("R10 bank_sel1", {94'h0, bank_sel}, 1);
        do_write(3'd4, 8'hB1); do_write(3'd5, 8'hB2);
        do_write(3'd6, 8'hB3); do_write(3'd7, 8'hB4);
        check("R5 bank1 export", {64'h0, bank_regs[63:32]}, {64'h0, 32'hB4B3_B2B1});
        do_read(3'd6, 8'hB3, "R5 trigger read");
        do_read(3'd4, 8'hB1, "R5 low thr read");

        // R6 bank 2
        do_write(3'd2, 8'h90);
        do_write(3'd4, 8'hC1); do_write(3'd5, 8'hC2);
        do_write(3'd6, 8'hC3); do_write(3'd7, 8'hC4);
        do_read(3'd5, 8'h01, "R6 hw id read");
        do_read(3'd7, 8'hC4, "R6 csr read");
        check("R6 bank2 export", {64'h0, bank_regs[95:64]}, {64'h0, 32'hC4C3_01C1});

        // R7 bank 3
        do_write(3'd2, 8'hD0);
        do_write(3'd4, 8'hE1); do_write(3'd5, 8'hE2);
        do_write(3'd6, 8'hE3); do_write(3'd7, 8'hE4);
        do_read(3'd4, 8'h00, "R7 bank3 off4");
        do_read(3'd7, 8'h00, "R7 bank3 off7");
        check("R7 banks unchanged", bank_regs, 96'hC4C3_01C1_B4B3_B2B1_A4A3_A2A1);
        check("R7 std unchanged", {32'h0, std_regs}, {64'h4433_2211_BF55_0000});
        do_read(3'd2, 8'hD0, "R3 efr readback");

        // R9 same-cycle read/write and hold
        do_rw(3'd2, 8'h10, 8'hD0, "R9 read before write");
        do_read(3'd2, 8'h10, "R9 new value");
        repeat (4) @(negedge clk);
        check("R9 rd hold", {88'h0, rd_data}, {88'h0, 8'h10});

        // R2 close, R3 and R8 retention
        do_write(3'd3, 8'h03);
        check("R2 view closes", {95'h0, view_open}, 0);
        do_read(3'd2, 8'h55, "R3 closed off2 plain");
        do_read(3'd4, 8'h11, "R8 closed off4 plain");
        do_write(3'd2, 8'h66);
        check("R3 efr unchanged by plain", {88'h0, efr_q}, {88'h0, 8'h10});
        do_write(3'd3, 8'hBF);
        do_read(3'd2, 8'h10, "R3 efr kept");
        do_read(3'd4, 8'hA1, "R8 bank0 kept");
        do_write(3'd3, 8'hBE);
        check("R2 near-key closes", {95'h0, view_open}, 0);
        do_read(3'd3, 8'hBE, "R2 lcr closed readback");

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", {95'h0, exp_q.size() == 0}, 1);
        finish_run();
    end

endmodule